// File: doc/BRIEF.md
# Flash-Scripted LCD Command Sequencer

This block plays back a small program kept as a byte stream in flash pages. A page reader delivers the bytes of one page at a time over a valid/ready stream and marks the final byte of each page. The sequencer decodes the bytes as instructions. Each instruction is a header byte that may be followed by operand bytes. Send instructions pass their payload bytes, in order, to an LCD write port together with a command/data flag. Timer instructions load a down-counter or wait for it to reach zero, which sets the frame rate. Jump instructions move execution to the start of another page.

The sequencer asks for pages through a one-cycle start pulse that carries a page number. After reset it fetches page 0. When a page runs out without a jump, it fetches the next page, and an instruction in progress carries on across the page boundary. When a jump is taken, the unused tail of the current page is drained, and then the target page is requested. The LCD serial protocol and the flash bus timing are handled by neighbouring blocks.

Top module: `frame_script_engine`

## Requirements
- R1: While `rst` is high, `pg_start` and `lcd_valid` stay low. In the first cycle after `rst` falls, `pg_start` is high with `pg_num` equal to 0.
- R2: Header byte layout: bits [7:6] are the opcode (00 = command send, 01 = data send, 10 = timer, 11 = jump). For sends, bits [5:0] hold the payload length minus one, so the length is 1 to 64. For the timer opcode, bit 5 clear means load and bit 5 set means wait.
- R3: A send forwards exactly its payload bytes, in stream order, on `lcd_byte`. `lcd_is_data` is 0 for a command send and 1 for a data send, and it does not change within one instruction.
- R4: `lcd_valid` is high only when an input byte is offered. While `lcd_valid` is high and `lcd_ready` is low, `in_ready` is low. No payload byte is lost or duplicated under any ready pattern.
- R5: A timer load takes a 16-bit value from the next two bytes, most significant byte first. The count drops by one every PRESCALE cycles. A load made while the count is running replaces the count and restarts the prescale phase.
- R6: A timer wait accepts no further byte until the count is zero. With input offered continuously and the wait header directly after a load of value N, the byte after the wait is accepted N*PRESCALE+2 cycles after the load's low byte. When the count is already zero, that byte is accepted 2 cycles after the wait header.
- R7: A jump takes a 16-bit page number from the next two bytes, most significant byte first. The bytes that remain in the current page, up to and including the one flagged `in_last`, are consumed without being executed or shown on the LCD port. Only then is the target page requested.
- R8: When a byte flagged `in_last` is accepted outside a jump, the next request is for the current page plus one. Execution continues from the state reached, so a send or operand may span pages.
- R9: `pg_start` lasts exactly one cycle, and `in_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_start | output | 1 | One-cycle page fetch request |
| pg_num | output | PAGE_W | Page to fetch, valid with `pg_start` |
| in_valid | input | 1 | Program byte offered by the page reader |
| in_byte | input | 8 | Program byte |
| in_last | input | 1 | Marks the final byte of a page |
| in_ready | output | 1 | Program byte accepted when high with `in_valid` |
| lcd_valid | output | 1 | Payload byte offered to the LCD port |
| lcd_byte | output | 8 | Payload byte |
| lcd_is_data | output | 1 | 0 = command byte, 1 = data byte |
| lcd_ready | input | 1 | LCD port takes the byte |

## Verification
The assertions assume the page reader follows stream rules. It keeps a byte and its `in_last` flag steady while `in_valid` waits for `in_ready`. It sends bytes only after a request, and it stops after the last byte of a page. The bench reader acts on each request only after the clock edge that ends it, streams exactly one page, and holds an offered byte until it is taken. Valid and ready gaps come from a shift-register pattern, except on the two pages that hold the timer programs. Those pages are streamed without gaps so that the cycle counts in R6 can be predicted exactly.

// File: rtl/seqlcd_pkg.sv
package seqlcd_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'b00,
        OP_DATA  = 2'b01,
        OP_TIMER = 2'b10,
        OP_JUMP  = 2'b11
    } opcode_e;

    typedef enum logic [3:0] {
        ST_START,
        ST_HDR,
        ST_PAY,
        ST_TMR_HI,
        ST_TMR_LO,
        ST_WAIT,
        ST_JMP_HI,
        ST_JMP_LO,
        ST_DRAIN
    } state_e;

    typedef struct packed {
        opcode_e    op;
        logic       sub;
        logic [4:0] low;
    } header_t;

    localparam int LEN_W = 6;

    function automatic logic [LEN_W-1:0] hdr_len(header_t h);
        return {h.sub, h.low};
    endfunction

    function automatic state_e hdr_next(header_t h);
        case (h.op)
            OP_CMD, OP_DATA: return ST_PAY;
            OP_TIMER:        return h.sub ? ST_WAIT : ST_TMR_HI;
            default:         return ST_JMP_HI;
        endcase
    endfunction

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int TMR_W    = 16,
    parameter int PRESCALE = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    localparam int PSC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PSC_W-1:0] PSC_MAX = PSC_W'(PRESCALE - 1);

    logic [PSC_W-1:0] presc;
    logic [TMR_W-1:0] count;
    logic             tick;

    assign tick = (presc == PSC_MAX);
    assign zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc <= '0;
            count <= '0;
        end else if (load) begin
            presc <= '0;
            count <= load_val;
        end else begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick && !zero) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/byte_gate.sv
module byte_gate (
    input  logic pass_en,
    input  logic take_en,
    input  logic in_valid,
    input  logic lcd_ready,
    output logic in_ready,
    output logic lcd_valid,
    output logic fire
);
    assign in_ready  = pass_en ? lcd_ready : take_en;
    assign lcd_valid = pass_en & in_valid;
    assign fire      = in_valid & in_ready;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seqlcd_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    input  logic              tmr_zero,
    output logic              pass_en,
    output logic              take_en,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              pg_start,
    output logic [PAGE_W-1:0] pg_num,
    output logic              lcd_is_data
);
    state_e           state, ret, nxt;
    logic [PAGE_W-1:0] page;
    logic [LEN_W-1:0]  rem;
    logic [7:0]        hi;
    logic              is_data;
    header_t           hdr;

    assign hdr         = header_t'(in_byte);
    assign pass_en     = (state == ST_PAY);
    assign take_en     = state inside {ST_HDR, ST_TMR_HI, ST_TMR_LO,
                                       ST_JMP_HI, ST_JMP_LO, ST_DRAIN};
    assign tmr_load    = fire && (state == ST_TMR_LO);
    assign tmr_val     = TMR_W'({hi, in_byte});
    assign pg_start    = (state == ST_START) && !rst;
    assign pg_num      = page;
    assign lcd_is_data = is_data;

    always_comb begin
        case (state)
            ST_HDR:    nxt = hdr_next(hdr);
            ST_PAY:    nxt = (rem == '0) ? ST_HDR : ST_PAY;
            ST_TMR_HI: nxt = ST_TMR_LO;
            ST_TMR_LO: nxt = ST_HDR;
            ST_JMP_HI: nxt = ST_JMP_LO;
            default:   nxt = ST_DRAIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_START;
            ret     <= ST_HDR;
            page    <= '0;
            rem     <= '0;
            hi      <= '0;
            is_data <= 1'b0;
        end else if (state == ST_START) begin
            state <= ret;
        end else if (state == ST_WAIT) begin
            if (tmr_zero) state <= ST_HDR;
        end else if (fire) begin
            case (state)
                ST_HDR: begin
                    rem     <= hdr_len(hdr);
                    is_data <= (hdr.op == OP_DATA);
                end
                ST_PAY:              rem  <= rem - 1'b1;
                ST_TMR_HI, ST_JMP_HI: hi  <= in_byte;
                ST_JMP_LO:           page <= PAGE_W'({hi, in_byte});
                default: ;
            endcase
            if (state == ST_JMP_LO || state == ST_DRAIN) begin
                if (in_last) begin
                    state <= ST_START;
                    ret   <= ST_HDR;
                end else begin
                    state <= ST_DRAIN;
                end
            end else if (in_last) begin
                page  <= page + 1'b1;
                ret   <= nxt;
                state <= ST_START;
            end else begin
                state <= nxt;
            end
        end
    end
endmodule

// File: rtl/frame_script_engine.sv
module frame_script_engine #(
    parameter int PAGE_W   = 16,
    parameter int PRESCALE = 1000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              pg_start,
    output logic [PAGE_W-1:0] pg_num,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic              in_ready,
    output logic              lcd_valid,
    output logic [7:0]        lcd_byte,
    output logic              lcd_is_data,
    input  logic              lcd_ready
);
    localparam int TMR_W = 16;

    logic             pass_en, take_en, fire, tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;

    seq_ctrl #(.PAGE_W(PAGE_W), .TMR_W(TMR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .in_byte     (in_byte),
        .in_last     (in_last),
        .tmr_zero    (tmr_zero),
        .pass_en     (pass_en),
        .take_en     (take_en),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pg_start    (pg_start),
        .pg_num      (pg_num),
        .lcd_is_data (lcd_is_data)
    );

    byte_gate u_gate (
        .pass_en   (pass_en),
        .take_en   (take_en),
        .in_valid  (in_valid),
        .lcd_ready (lcd_ready),
        .in_ready  (in_ready),
        .lcd_valid (lcd_valid),
        .fire      (fire)
    );

    pace_timer #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign lcd_byte = in_byte;
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
    input logic clk,
    input logic rst,
    input logic pg_start,
    input logic in_valid,
    input logic in_ready,
    input logic lcd_valid,
    input logic lcd_ready,
    input logic lcd_is_data
);
    assert_start_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
        pg_start |-> !in_ready);

    assert_start_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        pg_start |=> !pg_start);

    assert_backpressure_R4: assert property (@(posedge clk) disable iff (rst)
        (lcd_valid && !lcd_ready) |-> !in_ready);

    assert_lcd_needs_input_R4: assert property (@(posedge clk) disable iff (rst)
        lcd_valid |-> in_valid);

    assert_flag_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (lcd_valid && !lcd_ready) |=> (!lcd_valid || $stable(lcd_is_data)));
endmodule

bind frame_script_engine seq_chk u_chk (.*);

// File: tb/tb_frame_script_engine.sv
module tb_frame_script_engine;
    localparam int CLK_PERIOD = 10;
    localparam int PB         = 16;
    localparam int NP         = 16;
    localparam int P          = 4;
    localparam int LIMIT      = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pg_start;
    logic [15:0] pg_num;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       lcd_valid;
    logic [7:0] lcd_byte;
    logic       lcd_is_data;
    logic       lcd_ready = 1'b0;

    frame_script_engine #(.PAGE_W(16), .PRESCALE(P)) dut (
        .clk(clk), .rst(rst), .pg_start(pg_start), .pg_num(pg_num),
        .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
        .in_ready(in_ready), .lcd_valid(lcd_valid), .lcd_byte(lcd_byte),
        .lcd_is_data(lcd_is_data), .lcd_ready(lcd_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] mem [0:PB*NP-1];
    logic [8:0] exp_q [$];
    int         pg_exp [$];
    int         fire_cyc [0:PB*NP-1];
    int         wp, total, bad, cyc, pidx, rd_ptr;
    bit         active, st, fin, flc, first;
    logic [7:0] lf = 8'hA5;
    logic [8:0] e;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic put(int b);
        mem[wp] = 8'(b);
        wp++;
    endtask

    // R2 encodings: 00 command, 01 data, length-1 in bits 5:0
    task automatic send(bit d, int n, int base);
        put({d ? 2'b01 : 2'b00, 6'(n - 1)});
        for (int i = 0; i < n; i++) begin
            put(base + i);
            exp_q.push_back({d, 8'(base + i)});
        end
    endtask

    task automatic tload(int v);
        put(8'h80); put(v >> 8); put(v & 255);
    endtask

    task automatic twait();
        put(8'hA0);
    endtask

    task automatic jump(int p);
        put(8'hC0); put(p >> 8); put(p & 255);
    endtask

    initial begin
        for (int i = 0; i < PB*NP; i++) begin
            mem[i] = 8'hEE;
            fire_cyc[i] = 0;
        end
        wp = 0;
        send(0, 3, 8'hA0); send(1, 5, 8'h10); send(1, 4, 8'h20);
        send(0, 2, 8'h30); send(1, 8, 8'h40); jump(3);
        wp = 48;
        tload(100); tload(3); twait(); send(0, 1, 8'h5A);
        twait(); send(0, 1, 8'h5B); jump(5);
        wp = 80;
        send(1, 64, 8'h80); jump(10);
        wp = 160;
        send(1, 12, 8'hC0); jump(12);
        wp = 192;
        tload(5); twait(); jump(12);
        pg_exp = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 12, 12, 12};

        total = 0; bad = 0; cyc = 0; pidx = 0; rd_ptr = 0; active = 0; first = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pg_start == 1'b0, "R1", "pg_start in reset", pg_start, 0);
        chk(lcd_valid == 1'b0, "R1", "lcd_valid in reset", lcd_valid, 0);
        @(posedge clk); #1 rst = 1'b0;

        while (pidx < pg_exp.size() && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            st  = pg_start;
            fin = in_valid && in_ready;
            flc = lcd_valid && lcd_ready;
            if (first) begin
                chk(st == 1'b1, "R1", "first request", st, 1);
                chk(pg_num == 0, "R1", "first page", pg_num, 0);
                first = 0;
            end
            if (st) begin
                chk(in_ready == 1'b0, "R9", "in_ready during request", in_ready, 0);
                // R7 R8: page order, jump targets and sequential follow-on
                chk(pg_num == 16'(pg_exp[pidx]), "R8", "page sequence", pg_num, pg_exp[pidx]);
                pidx++;
            end
            if (lcd_valid && !lcd_ready)
                chk(in_ready == 1'b0, "R4", "backpressure", in_ready, 0);
            if (flc) begin
                // R2 R3: opcode decode, flag and byte order
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected LCD byte", {lcd_is_data, lcd_byte}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({lcd_is_data, lcd_byte} == e, "R3", "LCD byte", {lcd_is_data, lcd_byte}, e);
                end
            end
            if (fin) fire_cyc[rd_ptr] = cyc;

            @(posedge clk); #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (st) begin
                rd_ptr = (pg_num % NP) * PB;
                active = 1;
                in_valid = 1'b0;
            end else if (fin) begin
                if (rd_ptr % PB == PB - 1) active = 0;
                else rd_ptr++;
                in_valid = 1'b0;
            end
            if (!active) begin
                in_valid = 1'b0;
            end else if (!(in_valid && !fin)) begin
                if ((rd_ptr / PB == 3) || (rd_ptr / PB == 12)) in_valid = 1'b1;
                else in_valid = lf[0] | lf[1];
            end
            if ((rd_ptr / PB == 3) || (rd_ptr / PB == 12)) lcd_ready = 1'b1;
            else lcd_ready = lf[2] | lf[5];
            in_byte = mem[rd_ptr];
            in_last = (rd_ptr % PB == PB - 1);
        end

        chk(cyc < LIMIT, "R8", "watchdog", cyc, LIMIT);
        chk(exp_q.size() == 0, "R3", "LCD bytes left undelivered", exp_q.size(), 0);
        // R5: reload of 3 replaced the running count of 100
        chk(fire_cyc[55] - fire_cyc[53] == 3*P + 2, "R5", "reload restart delay",
            fire_cyc[55] - fire_cyc[53], 3*P + 2);
        // R6: wait with count already zero
        chk(fire_cyc[58] - fire_cyc[57] == 2, "R6", "wait at zero",
            fire_cyc[58] - fire_cyc[57], 2);
        // R6: wait after a fresh load of 5
        chk(fire_cyc[196] - fire_cyc[194] == 5*P + 2, "R6", "wait after load",
            fire_cyc[196] - fire_cyc[194], 5*P + 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule